// File: doc/BRIEF.md
# 8-bit ALU with status flag register

This block performs one arithmetic, logical, rotate or shift operation per cycle on an 8-bit destination operand and an 8-bit source operand. The result comes out combinationally. It also computes a new set of five status flags: carry, zero, sign, overflow and add/subtract kind. These flags are stored in a register when the caller raises the flag-write enable on a rising clock edge. The carry-in of the with-carry arithmetic and the through-carry rotates comes from that stored carry.

A write-enable output tells the surrounding datapath whether the result is meant to be written back to the destination. The bit-test operation only sets flags and never asks for a write. The add/subtract kind flag does not correct anything itself. It records whether the last arithmetic operation was an addition or a subtraction, so that a later decimal correction step can choose its rule.

Top module: `alu8_flag_unit`

## Requirements
- R1: Opcodes 0 (add) and 1 (add with carry) give result = dst + src (+ stored C for opcode 1) mod 256, and the next C is the unsigned carry out of bit 7.
- R2: Opcodes 2 (subtract) and 3 (subtract with borrow) give result = dst - src (- stored C for opcode 3) mod 256, and the next C is 1 exactly when a borrow occurs.
- R3: After add-type opcodes, V is 1 when dst and src have the same sign and the result sign differs. After subtract-type opcodes, V is 1 when dst and src differ in sign and the result sign equals the sign of src.
- R4: Opcodes 4, 5 and 6 give dst AND src, dst OR src and dst XOR src. They clear V and leave C unchanged.
- R5: Opcode 7 (bit test) drives dst_we_o low, sets Z from (dst AND src) == 0 and S from bit 7 of that value, clears V and leaves C unchanged. Every other opcode from 0 to 13 drives dst_we_o high.
- R6: For opcodes 0 to 13, Z is 1 exactly when the 8-bit result is 00h, and S equals bit 7 of the result.
- R7: Opcodes 8 to 11 rotate: 8 rotates left with bit 7 going to bit 0, 9 rotates left through C, 10 rotates right with bit 0 going to bit 7, and 11 rotates right through C. C receives the bit shifted out, and V is 1 when bit 7 of dst differs from bit 7 of the result.
- R8: Opcode 12 shifts left with 0 entering bit 0, and opcode 13 shifts right with 0 entering bit 7. C receives the bit shifted out, and V is 1 when bit 7 changed.
- R9: The D flag becomes 0 after opcodes 0 and 1 and becomes 1 after opcodes 2 and 3. Every other opcode leaves it unchanged.
- R10: The flags (flags_o bit 0 = C, bit 1 = Z, bit 2 = S, bit 3 = V, bit 4 = D) change only on a rising edge with flag_we_i high. A synchronous reset clears all of them to 0.
- R11: Opcodes 14 and 15 are unassigned. They drive dst_we_o low, result_o equals dst_i, and they leave all flags unchanged even with flag_we_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| dst_i | input | 8 | Destination operand |
| src_i | input | 8 | Source operand |
| flag_we_i | input | 1 | Commit the new flags on this edge |
| result_o | output | 8 | Combinational result |
| dst_we_o | output | 1 | Result is meant for the destination |
| flags_o | output | 5 | Stored flags {D,V,S,Z,C} |

## Verification
Several rules are checked on every cycle against the values seen before the edge: flags stay put without the enable, zero and sign agree with the previous result, overflow is clear and carry is held after logic ops, the kind flag follows add or subtract, and the bit test never asks for a write. The arithmetic values themselves can only be shown by the bench's scenarios. These are the carry and borrow chains through the stored carry, the signed overflow corners at 7Fh/80h, the exact rotate and shift bit patterns, and a reset in the middle of a run.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_TST  = 4'd7,
        OP_RL   = 4'd8,
        OP_RLC  = 4'd9,
        OP_RR   = 4'd10,
        OP_RRC  = 4'd11,
        OP_SLA  = 4'd12,
        OP_SRL  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    // packed order gives bit4=d ... bit0=c
    typedef struct packed {
        logic d;
        logic v;
        logic s;
        logic z;
        logic c;
    } alu_flags_t;

    typedef enum logic [2:0] {
        SH_RL  = 3'd0,
        SH_RLC = 3'd1,
        SH_RR  = 3'd2,
        SH_RRC = 3'd3,
        SH_SLA = 3'd4,
        SH_SRL = 3'd5
    } shift_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W:0] ext;

    always_comb begin
        if (sub_i) begin
            ext = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
        end else begin
            ext = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        end
        res_o  = ext[MSB:0];
        // for subtraction the wrapped top bit is the borrow
        cout_o = ext[W];
        if (sub_i) begin
            ovf_o = (a_i[MSB] != b_i[MSB]) && (ext[MSB] == b_i[MSB]);
        end else begin
            ovf_o = (a_i[MSB] == b_i[MSB]) && (ext[MSB] != a_i[MSB]);
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (sel_i)
            2'd1:    res_o = a_i | b_i;
            2'd2:    res_o = a_i ^ b_i;
            default: res_o = a_i & b_i;   // and, bit test
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   sel_i,
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic in_bit;
    logic left;

    always_comb begin
        left   = 1'b1;
        in_bit = 1'b0;
        unique case (shift_sel_e'(sel_i))
            SH_RL:  begin left = 1'b1; in_bit = a_i[MSB]; end
            SH_RLC: begin left = 1'b1; in_bit = cin_i;    end
            SH_RR:  begin left = 1'b0; in_bit = a_i[0];   end
            SH_RRC: begin left = 1'b0; in_bit = cin_i;    end
            SH_SLA: begin left = 1'b1; in_bit = 1'b0;     end
            SH_SRL: begin left = 1'b0; in_bit = 1'b0;     end
            default: begin left = 1'b1; in_bit = 1'b0;    end
        endcase
        if (left) begin
            res_o  = {a_i[MSB-1:0], in_bit};
            cout_o = a_i[MSB];
        end else begin
            res_o  = {in_bit, a_i[MSB:1]};
            cout_o = a_i[0];
        end
        ovf_o = a_i[MSB] ^ res_o[MSB];
    end
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] src_i,
    input  logic         flag_we_i,
    output logic [W-1:0] result_o,
    output logic         dst_we_o,
    output logic [4:0]   flags_o
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] result;
        logic         dst_we;
        alu_flags_t   flags;
    } alu_next_t;

    alu_flags_t flags_d, flags_q;
    alu_next_t  nxt;
    alu_op_e    op;

    logic [W-1:0] as_res, lg_res, sh_res;
    logic         as_c, as_v, sh_c, sh_v;
    logic         is_sub, use_cin;

    assign op      = alu_op_e'(op_i);
    assign is_sub  = (op == OP_SUB) || (op == OP_SBC);
    assign use_cin = (op == OP_ADC) || (op == OP_SBC);

    alu8_addsub #(.W(W)) u_addsub (
        .a_i    (dst_i),
        .b_i    (src_i),
        .cin_i  (use_cin & flags_q.c),
        .sub_i  (is_sub),
        .res_o  (as_res),
        .cout_o (as_c),
        .ovf_o  (as_v)
    );

    alu8_logic #(.W(W)) u_logic (
        .sel_i (op_i[1:0]),
        .a_i   (dst_i),
        .b_i   (src_i),
        .res_o (lg_res)
    );

    alu8_shift #(.W(W)) u_shift (
        .sel_i  (op_i[2:0] - 3'd0),
        .a_i    (dst_i),
        .cin_i  (flags_q.c),
        .res_o  (sh_res),
        .cout_o (sh_c),
        .ovf_o  (sh_v)
    );

    always_comb begin
        nxt.result = dst_i;
        nxt.dst_we = 1'b0;
        nxt.flags  = flags_q;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                nxt.result  = as_res;
                nxt.dst_we  = 1'b1;
                nxt.flags.c = as_c;
                nxt.flags.v = as_v;
                nxt.flags.d = is_sub;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt.result  = lg_res;
                nxt.dst_we  = 1'b1;
                nxt.flags.v = 1'b0;
            end
            OP_TST: begin
                nxt.result  = lg_res;
                nxt.dst_we  = 1'b0;
                nxt.flags.v = 1'b0;
            end
            OP_RL, OP_RLC, OP_RR, OP_RRC, OP_SLA, OP_SRL: begin
                nxt.result  = sh_res;
                nxt.dst_we  = 1'b1;
                nxt.flags.c = sh_c;
                nxt.flags.v = sh_v;
            end
            default: begin
                nxt.result = dst_i;
                nxt.dst_we = 1'b0;
            end
        endcase
        if (op != OP_RSV0 && op != OP_RSV1) begin
            nxt.flags.z = (nxt.result == '0);
            nxt.flags.s = nxt.result[MSB];
        end
        flags_d = flag_we_i ? nxt.flags : flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign result_o = nxt.result;
    assign dst_we_o = nxt.dst_we;
    assign flags_o  = flags_q;

endmodule

// File: rtl/alu8_flag_unit_chk.sv
module alu8_flag_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   op_i,
    input logic [W-1:0] dst_i,
    input logic [W-1:0] src_i,
    input logic         flag_we_i,
    input logic [W-1:0] result_o,
    input logic         dst_we_o,
    input logic [4:0]   flags_o
);
    logic is_logic, is_add, is_sub, is_valid;
    assign is_logic = (op_i >= 4'd4) && (op_i <= 4'd7);
    assign is_add   = (op_i == 4'd0) || (op_i == 4'd1);
    assign is_sub   = (op_i == 4'd2) || (op_i == 4'd3);
    assign is_valid = (op_i <= 4'd13);

    p_reset_clear_r10: assert property (@(posedge clk) rst |=> flags_o == 5'd0);

    p_hold_no_we_r10: assert property (@(posedge clk) disable iff (rst)
        (!flag_we_i || !is_valid) |=> $stable(flags_o));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && is_logic) |=> !flags_o[3]);

    p_carry_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && is_logic) |=> flags_o[0] == $past(flags_o[0]));

    p_zero_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && is_valid) |=>
            (flags_o[1] == ($past(result_o) == '0)) && (flags_o[2] == $past(result_o[W-1])));

    p_kind_add_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && is_add) |=> !flags_o[4]);

    p_kind_sub_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && is_sub) |=> flags_o[4]);

    p_test_no_write_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd7) |-> (!dst_we_o && ((result_o == '0) == ((dst_i & src_i) == '0))));

    p_unassigned_r11: assert property (@(posedge clk) disable iff (rst)
        (!is_valid) |-> (!dst_we_o && result_o == dst_i));

endmodule

bind alu8_flag_unit alu8_flag_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .dst_i     (dst_i),
    .src_i     (src_i),
    .flag_we_i (flag_we_i),
    .result_o  (result_o),
    .dst_we_o  (dst_we_o),
    .flags_o   (flags_o)
);

// File: tb/tb_alu8_flag_unit.sv
module tb_alu8_flag_unit;

    typedef struct {
        logic [7:0] r;
        logic       we;
        logic [4:0] f;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op = '0;
    logic [7:0] dst = '0, src = '0;
    logic       fwe = 1'b0;
    logic [7:0] result;
    logic       dst_we;
    logic [4:0] flags;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [4:0] mflags = '0;   // model flags {D,V,S,Z,C}
    exp_t q[$];

    always #5 clk = ~clk;

    alu8_flag_unit dut (
        .clk(clk), .rst(rst), .op_i(op), .dst_i(dst), .src_i(src),
        .flag_we_i(fwe), .result_o(result), .dst_we_o(dst_we), .flags_o(flags)
    );

    function automatic exp_t model(input logic [3:0] o, input logic [7:0] d,
                                   input logic [7:0] s, input logic we, input logic [4:0] fi);
        exp_t e;
        logic [8:0] t;
        logic c, z, sg, v, dk;
        {dk, v, sg, z, c} = fi;
        e.r = d; e.we = 1'b1;
        case (o)
            4'd0, 4'd1: begin   // R1 R3 R9
                t = d + s + ((o == 4'd1) ? fi[0] : 1'b0);
                e.r = t[7:0]; c = t[8]; dk = 1'b0;
                v = (d[7] == s[7]) && (e.r[7] != d[7]);
            end
            4'd2, 4'd3: begin   // R2 R3 R9
                t = {1'b0, d} - {1'b0, s} - ((o == 4'd3) ? fi[0] : 1'b0);
                e.r = t[7:0]; c = ({1'b0, d} < ({1'b0, s} + ((o == 4'd3) ? fi[0] : 1'b0)));
                dk = 1'b1;
                v = (d[7] != s[7]) && (e.r[7] == s[7]);
            end
            4'd4: begin e.r = d & s; v = 1'b0; end
            4'd5: begin e.r = d | s; v = 1'b0; end
            4'd6: begin e.r = d ^ s; v = 1'b0; end
            4'd7: begin e.r = d & s; v = 1'b0; e.we = 1'b0; end
            4'd8:  begin e.r = {d[6:0], d[7]};  c = d[7]; end
            4'd9:  begin e.r = {d[6:0], fi[0]}; c = d[7]; end
            4'd10: begin e.r = {d[0], d[7:1]};  c = d[0]; end
            4'd11: begin e.r = {fi[0], d[7:1]}; c = d[0]; end
            4'd12: begin e.r = {d[6:0], 1'b0};  c = d[7]; end
            4'd13: begin e.r = {1'b0, d[7:1]};  c = d[0]; end
            default: begin e.r = d; e.we = 1'b0; end
        endcase
        if (o >= 4'd8 && o <= 4'd13) v = d[7] ^ e.r[7];
        if (o <= 4'd13) begin z = (e.r == 8'h00); sg = e.r[7]; end
        e.f = (we && o <= 4'd13) ? {dk, v, sg, z, c} : fi;
        return e;
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [7:0] d, input logic [7:0] s,
                         input logic we, input string req);
        exp_t e;
        @(negedge clk);
        op = o; dst = d; src = s; fwe = we;
        e = model(o, d, s, we, mflags);
        e.req = req;
        mflags = e.f;
        #1;
        q.push_back(e);
    endtask

    // monitor: result before the edge, flags after it
    initial begin
        forever begin
            exp_t e;
            wait (q.size() > 0);
            e = q.pop_front();
            check(e.req, "result", result, e.r);
            check(e.req, "dst_we", {7'd0, dst_we}, {7'd0, e.we});
            @(posedge clk);
            #1;
            check(e.req, "flags", {3'd0, flags}, {3'd0, e.f});
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10", "reset flags", {3'd0, flags}, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        drive(4'd0, 8'h7F, 8'h01, 1'b1, "R3");   // signed overflow, S set
        drive(4'd0, 8'hFF, 8'h01, 1'b1, "R1");   // zero and carry
        drive(4'd1, 8'h10, 8'h20, 1'b1, "R1");   // adds stored carry
        drive(4'd2, 8'h80, 8'h01, 1'b1, "R3");   // sub overflow
        drive(4'd2, 8'h00, 8'h01, 1'b1, "R2");   // borrow
        drive(4'd3, 8'h05, 8'h05, 1'b1, "R2");   // borrow feeds in -> FF
        drive(4'd4, 8'hF0, 8'h3C, 1'b1, "R4");   // C kept from borrow
        drive(4'd5, 8'h00, 8'h00, 1'b1, "R6");
        drive(4'd6, 8'hAA, 8'h55, 1'b1, "R4");
        drive(4'd7, 8'hF0, 8'h0F, 1'b1, "R5");   // test zero, no write
        drive(4'd7, 8'h81, 8'h80, 1'b1, "R5");
        drive(4'd9, 8'h81, 8'h00, 1'b1, "R7");   // rotate through carry
        drive(4'd8, 8'h80, 8'h00, 1'b1, "R7");
        drive(4'd10, 8'h01, 8'h00, 1'b1, "R7");
        drive(4'd11, 8'h02, 8'h00, 1'b1, "R7");
        drive(4'd12, 8'h40, 8'h00, 1'b1, "R8");  // shift into sign
        drive(4'd13, 8'h81, 8'h00, 1'b1, "R8");
        drive(4'd0, 8'h01, 8'h01, 1'b1, "R9");
        drive(4'd6, 8'h01, 8'h01, 1'b1, "R9");   // D stays 0
        drive(4'd2, 8'h01, 8'h01, 1'b0, "R10");  // no commit
        drive(4'd14, 8'h5A, 8'h00, 1'b1, "R11");
        drive(4'd15, 8'h00, 8'h33, 1'b1, "R11");
        for (int i = 0; i < 300; i++) begin
            drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 1'($urandom), "R6");
        end
        wait (q.size() == 0);
        @(posedge clk); #2;

        // reset in the middle of a run
        drive(4'd2, 8'h00, 8'h90, 1'b1, "R10");
        wait (q.size() == 0);
        @(posedge clk); #2;
        @(negedge clk); rst = 1'b1; fwe = 1'b0;
        @(posedge clk); #1;
        check("R10", "mid reset flags", {3'd0, flags}, 8'h00);
        @(negedge clk); rst = 1'b0; mflags = '0;
        drive(4'd1, 8'h01, 8'h01, 1'b1, "R1");
        wait (q.size() == 0);
        @(posedge clk); #3;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule